// File: doc/BRIEF.md
# Transition Capture Engine with Time Tags

This block turns a stream of multi-channel samples into a compact record of signal activity. Every accepted sample is compared with the one before it. An entry goes to acquisition memory only when the word has changed. Each entry carries the data word and a time tag that counts the sample periods since the previous entry, so a waveform can be rebuilt later. How much time one memory fill covers therefore depends on how busy the inputs are, not on depth times sample period.

A capture starts with a pulse on `arm`. The first sample after arming is always kept as a starting reference. If the input stays quiet long enough that the tag would run past its largest value, a repeat entry is written so that the gap stays measurable. The first sample flagged with `s_trig` is always stored, and its memory index is held on `trig_idx`. A post-trigger counter then lets `post_delay` further samples through before the capture ends.

A capture also ends when the memory holds `SLOTS/2` entries, because each entry uses one data slot and one tag slot, or when `stop` is pulsed. Samples arrive on a valid/ready stream. The memory write port is also valid/ready and holds one registered entry. While that entry waits for `m_ready`, `s_ready` is low, so back-pressure from memory stalls the sample stream and no sample is lost. Stalled cycles are not sample periods and do not advance the tag.

Top module: `ttcap_top`

## Requirements
- R1: A pulse on `arm` (it takes priority over `stop`) clears the entry count, `trig_hit`, `trig_idx`, any pending write and `done`, and starts a new capture. Before the first arm, `s_ready`, `m_valid` and `done` are 0.
- R2: The first sample accepted after arming is always written, with tag 0, even if it equals the last sample of an earlier capture.
- R3: A later accepted sample is written only if its data differs from the previous accepted sample, or if R5 or R6 applies. Its tag is the number of accepted samples from the previous written entry to this one (1 for back-to-back entries).
- R4: Entries are written at addresses 0, 1, 2, … in order, and `count` equals the number of entries written in the current capture.
- R5: When 2^TAG_W−1 accepted samples have passed since the last entry with no change, the current sample is written anyway, with the all-ones tag.
- R6: The first accepted sample with `s_trig`=1 is always written. `trig_hit` goes to 1 and `trig_idx` takes that entry's address. Later trigger flags are ignored.
- R7: After the trigger sample, exactly `post_delay` further samples are accepted (none when it is 0). Then the capture ends. `post_delay` is read at the trigger sample.
- R8: When the entry at address SLOTS/2−1 is written, the capture ends, with or without a trigger.
- R9: A `stop` pulse during a capture ends it. No sample offered afterwards is accepted and `count` does not change.
- R10: While `m_valid`=1 and `m_ready`=0, `s_ready` is 0 and `m_addr`, `m_data` and `m_tag` hold their values. `s_ready` is also 0 whenever no capture is running.
- R11: `done` is 1 once the capture has ended and its last entry has been taken from the write port. It stays 1, with `s_ready` at 0, until the next arm.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock; one accepted sample per sample period |
| rst_n | input | 1 | Active-low asynchronous reset |
| arm | input | 1 | Pulse: start a new capture |
| stop | input | 1 | Pulse: end the running capture |
| post_delay | input | DELAY_W | Samples to accept after the trigger sample |
| s_valid | input | 1 | Sample stream valid |
| s_ready | output | 1 | Sample stream ready |
| s_data | input | DATA_W | Sample word |
| s_trig | input | 1 | Trigger flag travelling with the sample |
| m_valid | output | 1 | Memory write valid |
| m_ready | input | 1 | Memory write accepted |
| m_addr | output | $clog2(SLOTS/2) | Entry address |
| m_data | output | DATA_W | Stored data word |
| m_tag | output | TAG_W | Sample periods since previous entry |
| done | output | 1 | Capture finished and drained |
| count | output | $clog2(SLOTS/2+1) | Entries written this capture |
| trig_hit | output | 1 | Trigger sample has been stored |
| trig_idx | output | $clog2(SLOTS/2) | Address of the trigger entry |

## Verification
The entry for a sample accepted at a rising edge is visible on the write port right after that same edge, since there is exactly one register stage. `count`, `trig_hit` and `trig_idx` update at that edge too. `done` rises right after the edge where the final entry is taken.

`s_ready` is combinational on the current write-port state. The bench therefore drives samples 1 ns after a rising edge and changes `m_ready` 2 ns after it. It reads `s_ready` and the write port at the falling edge, so a handshake it sees there completes at the next rising edge. A reference model steps only on beats the bench has seen accepted, and it queues the expected entries. The monitor pops one entry from the queue for every write it sees taken.

// File: rtl/ttcap_pkg.sv
package ttcap_pkg;
  typedef enum logic [1:0] {
    PH_IDLE = 2'd0,
    PH_RUN  = 2'd1,
    PH_END  = 2'd2
  } phase_e;
endpackage

// File: rtl/ttcap_change.sv
// Holds the previous accepted word and flags the first sample of a capture.
module ttcap_change #(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              clear,
  input  logic              take,
  input  logic [DATA_W-1:0] din,
  output logic              first,
  output logic              differs
);
  logic [DATA_W-1:0] last_q;
  logic              fresh_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      last_q  <= '0;
      fresh_q <= 1'b1;
    end else if (clear) begin
      fresh_q <= 1'b1;
    end else if (take) begin
      last_q  <= din;
      fresh_q <= 1'b0;
    end
  end

  assign first   = fresh_q;
  assign differs = (din != last_q);
endmodule

// File: rtl/ttcap_gap.sv
// Counts accepted samples since the last stored entry.
module ttcap_gap #(
  parameter int TAG_W = 6
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clear,
  input  logic             take,
  input  logic             store,
  output logic [TAG_W-1:0] gap,
  output logic             at_max
);
  localparam logic [TAG_W-1:0] GAP_TOP = '1;
  localparam logic [TAG_W-1:0] GAP_ONE = TAG_W'(1);

  logic [TAG_W-1:0] gap_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                gap_q <= GAP_ONE;
    else if (clear)            gap_q <= GAP_ONE;
    else if (take && store)    gap_q <= GAP_ONE;
    else if (take)             gap_q <= gap_q + GAP_ONE;
  end

  assign gap    = gap_q;
  assign at_max = (gap_q == GAP_TOP);

  // R5: a saturated gap must force the store decision made in the top level
  a_r5_gap_forces_store: assert property (@(posedge clk) disable iff (!rst_n)
    (take && at_max && !clear) |-> store);
endmodule

// File: rtl/ttcap_posttrig.sv
// Detects the trigger sample and counts the post-trigger window.
module ttcap_posttrig #(
  parameter int DELAY_W = 20
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               clear,
  input  logic               take,
  input  logic               trig_in,
  input  logic [DELAY_W-1:0] delay,
  output logic               hit,
  output logic               fire_now,
  output logic               last
);
  localparam logic [DELAY_W-1:0] D_ONE = DELAY_W'(1);

  logic               hit_q;
  logic [DELAY_W-1:0] rem_q;

  assign fire_now = take && trig_in && !hit_q;
  assign last     = fire_now ? (delay == '0) : (hit_q && take && rem_q == D_ONE);
  assign hit      = hit_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hit_q <= 1'b0;
      rem_q <= '0;
    end else if (clear) begin
      hit_q <= 1'b0;
      rem_q <= '0;
    end else if (fire_now) begin
      hit_q <= 1'b1;
      rem_q <= delay;
    end else if (hit_q && take && rem_q != '0) begin
      rem_q <= rem_q - D_ONE;
    end
  end

  // R6: once the trigger is recorded, only a new arm can clear it
  a_r6_hit_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    (hit_q && !clear) |=> hit_q);
endmodule

// File: rtl/ttcap_top.sv
module ttcap_top #(
  parameter int DATA_W  = 8,
  parameter int TAG_W   = 6,
  parameter int SLOTS   = 64,
  parameter int DELAY_W = 20,
  localparam int ENTRIES = SLOTS / 2,
  localparam int ADDR_W  = $clog2(ENTRIES),
  localparam int CNT_W   = $clog2(ENTRIES + 1)
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               arm,
  input  logic               stop,
  input  logic [DELAY_W-1:0] post_delay,
  input  logic               s_valid,
  output logic               s_ready,
  input  logic [DATA_W-1:0]  s_data,
  input  logic               s_trig,
  output logic               m_valid,
  input  logic               m_ready,
  output logic [ADDR_W-1:0]  m_addr,
  output logic [DATA_W-1:0]  m_data,
  output logic [TAG_W-1:0]   m_tag,
  output logic               done,
  output logic [CNT_W-1:0]   count,
  output logic               trig_hit,
  output logic [ADDR_W-1:0]  trig_idx
);
  import ttcap_pkg::*;

  localparam logic [CNT_W-1:0] LAST_SLOT = CNT_W'(ENTRIES - 1);
  localparam logic [CNT_W-1:0] FULL_CNT  = CNT_W'(ENTRIES);

  phase_e             ph_q;
  logic [CNT_W-1:0]   count_q;
  logic               take, store, finish, full_hit;
  logic               first, differs, at_max, fire_now, last;
  logic [TAG_W-1:0]   gap;
  logic [TAG_W-1:0]   tag_now;

  assign s_ready  = (ph_q == PH_RUN) && (!m_valid || m_ready);
  assign take     = s_valid && s_ready && !arm;
  assign store    = take && (first || differs || at_max || fire_now);
  assign full_hit = store && (count_q == LAST_SLOT);
  assign finish   = take && (last || full_hit);
  assign tag_now  = first ? '0 : gap;

  ttcap_change #(.DATA_W(DATA_W)) u_change (
    .clk(clk), .rst_n(rst_n), .clear(arm), .take(take), .din(s_data),
    .first(first), .differs(differs)
  );

  ttcap_gap #(.TAG_W(TAG_W)) u_gap (
    .clk(clk), .rst_n(rst_n), .clear(arm), .take(take), .store(store),
    .gap(gap), .at_max(at_max)
  );

  ttcap_posttrig #(.DELAY_W(DELAY_W)) u_post (
    .clk(clk), .rst_n(rst_n), .clear(arm), .take(take), .trig_in(s_trig),
    .delay(post_delay), .hit(trig_hit), .fire_now(fire_now), .last(last)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ph_q     <= PH_IDLE;
      m_valid  <= 1'b0;
      m_addr   <= '0;
      m_data   <= '0;
      m_tag    <= '0;
      count_q  <= '0;
      trig_idx <= '0;
    end else if (arm) begin
      ph_q     <= PH_RUN;
      m_valid  <= 1'b0;
      count_q  <= '0;
      trig_idx <= '0;
    end else begin
      if (m_valid && m_ready) m_valid <= 1'b0;
      if (store) begin
        m_valid <= 1'b1;
        m_addr  <= count_q[ADDR_W-1:0];
        m_data  <= s_data;
        m_tag   <= tag_now;
        count_q <= count_q + CNT_W'(1);
      end
      if (fire_now) trig_idx <= count_q[ADDR_W-1:0];
      if (ph_q == PH_RUN && (finish || stop)) ph_q <= PH_END;
    end
  end

  assign count = count_q;
  assign done  = (ph_q == PH_END) && !m_valid;

  // R10: a stalled write keeps its contents
  a_r10_hold_stalled: assert property (@(posedge clk) disable iff (!rst_n)
    (m_valid && !m_ready && !arm) |=> (m_valid && $stable(m_addr) && $stable(m_data) && $stable(m_tag)));

  // R4: consecutive writes use consecutive addresses
  a_r4_addr_step: assert property (@(posedge clk) disable iff (!rst_n)
    (m_valid && m_ready && !arm) |=> (!m_valid || m_addr == $past(m_addr) + 1'b1));

  // R2: the entry at address zero is the reference with a zero tag
  a_r2_first_tag: assert property (@(posedge clk) disable iff (!rst_n)
    (m_valid && m_addr == '0) |-> (m_tag == '0));

  // R11: a finished capture accepts nothing and has nothing pending
  a_r11_done_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> (!s_ready && !m_valid));

  // R8: the entry count never exceeds the usable memory
  a_r8_capacity: assert property (@(posedge clk) disable iff (!rst_n)
    count_q <= FULL_CNT);
endmodule

// File: tb/ttcap_top_test.sv
`timescale 1ns/1ps
module ttcap_top_test;
  localparam int DW = 8, TW = 6, SL = 64, DLW = 20;
  localparam int ENT = SL / 2;
  localparam int AW = $clog2(ENT), CW = $clog2(ENT + 1);
  localparam int TMAX = (1 << TW) - 1;

  logic clk = 1'b0;
  logic rst_n, arm, stop, s_valid, s_trig, m_ready;
  logic [DLW-1:0] post_delay;
  logic [DW-1:0] s_data;
  logic s_ready, m_valid, done, trig_hit;
  logic [AW-1:0] m_addr, trig_idx;
  logic [DW-1:0] m_data;
  logic [TW-1:0] m_tag;
  logic [CW-1:0] count;

  always #2.5 clk = ~clk;

  ttcap_top #(.DATA_W(DW), .TAG_W(TW), .SLOTS(SL), .DELAY_W(DLW)) uut (
    .clk(clk), .rst_n(rst_n), .arm(arm), .stop(stop), .post_delay(post_delay),
    .s_valid(s_valid), .s_ready(s_ready), .s_data(s_data), .s_trig(s_trig),
    .m_valid(m_valid), .m_ready(m_ready), .m_addr(m_addr), .m_data(m_data),
    .m_tag(m_tag), .done(done), .count(count), .trig_hit(trig_hit), .trig_idx(trig_idx)
  );

  typedef struct { int a; int d; int t; string req; } ent_t;
  ent_t exp_q[$];

  int total = 0, bad = 0;
  bit m_first, m_tseen, m_fin, rdy_rand;
  int m_prev, m_gap, m_cnt, m_rem, m_tidx, delay_cfg;
  logic [7:0] lfsr = 8'h5a;

  task automatic chk(string req, int act, int exp, string what);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  task automatic summary();
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  endtask

  // reference model, stepped once per accepted sample
  task automatic model_take(int d, bit t);
    bit trig_now, st, lst;
    ent_t e;
    trig_now = t && !m_tseen;
    st = m_first || (d != m_prev) || (m_gap == TMAX) || trig_now;
    if (st) begin
      e.a = m_cnt; e.d = d; e.t = m_first ? 0 : m_gap;
      e.req = m_first ? "R2" : trig_now ? "R6" : (d != m_prev) ? "R3" : "R5";
      exp_q.push_back(e);
      if (trig_now) m_tidx = m_cnt;
      m_cnt++;
      m_gap = 1;
    end else m_gap++;
    m_prev = d;
    m_first = 0;
    lst = 0;
    if (trig_now) begin m_tseen = 1; m_rem = delay_cfg; lst = (delay_cfg == 0); end
    else if (m_tseen) begin lst = (m_rem == 1); m_rem--; end
    if (lst || (st && m_cnt == ENT)) m_fin = 1;
  endtask

  // monitor: write-port ready pattern and scoreboard pop
  initial begin
    m_ready = 1'b1;
    forever begin
      @(posedge clk); #2;
      lfsr = {lfsr[6:0], lfsr[7] ^ lfsr[5] ^ lfsr[4] ^ lfsr[3]};
      m_ready = rdy_rand ? (lfsr[0] | lfsr[3]) : 1'b1;
      @(negedge clk);
      if (rst_n && m_valid && !m_ready) chk("R10", int'(s_ready), 0, "s_ready during stall");
      if (rst_n && m_valid && m_ready) begin
        if (exp_q.size() == 0) chk("R3", 1, 0, "unexpected entry");
        else begin
          ent_t e;
          e = exp_q.pop_front();
          chk("R4", int'(m_addr), e.a, "entry address");
          chk(e.req, int'(m_data), e.d, "entry data");
          chk(e.req, int'(m_tag), e.t, "entry tag");
        end
      end
    end
  end

  // all driver tasks are entered 1 ns after a rising edge
  task automatic send(int d, bit t);
    if (m_fin) return;
    s_valid = 1'b1; s_data = DW'(d); s_trig = t;
    forever begin
      @(negedge clk);
      if (s_ready) begin
        @(posedge clk);
        model_take(d, t);
        #1; s_valid = 1'b0; s_trig = 1'b0;
        break;
      end
      @(posedge clk); #1;
    end
  endtask

  task automatic idle(int n);
    repeat (n) begin @(posedge clk); #1; end
  endtask

  task automatic arm_go(int dly);
    delay_cfg = dly; post_delay = DLW'(dly);
    arm = 1'b1;
    @(posedge clk); #1;
    arm = 1'b0;
    m_first = 1; m_tseen = 0; m_fin = 0; m_cnt = 0; m_gap = 1; m_tidx = 0;
    exp_q.delete();
    chk("R1", int'(count), 0, "count after arm");
    chk("R1", int'(done), 0, "done after arm");
    chk("R1", int'(trig_hit), 0, "trig_hit after arm");
  endtask

  task automatic do_stop();
    stop = 1'b1;
    @(posedge clk); #1;
    stop = 1'b0;
    m_fin = 1;
  endtask

  task automatic wait_done(string req);
    for (int i = 0; i < 500 && !done; i++) @(negedge clk);
    if (!done) @(negedge clk);
    chk(req, int'(done), 1, "done");
    chk(req, exp_q.size(), 0, "entries drained");
    chk(req, int'(count), m_cnt, "count");
    chk("R11", int'(s_ready), 0, "s_ready when done");
    @(posedge clk); #1;
  endtask

  initial begin
    #(5.0 * 150000);
    total++; bad++;
    $display("FAIL watchdog: actual=hung expected=finished");
    summary();
  end

  initial begin
    rst_n = 1'b0; arm = 1'b0; stop = 1'b0; s_valid = 1'b0; s_trig = 1'b0;
    s_data = '0; post_delay = '0; rdy_rand = 0; m_fin = 1;
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;
    @(negedge clk);
    chk("R1", int'(done), 0, "done after reset");
    chk("R1", int'(count), 0, "count after reset");
    chk("R10", int'(s_ready), 0, "s_ready while idle");
    chk("R1", int'(m_valid), 0, "m_valid after reset");
    @(posedge clk); #1;

    // change detection, trigger on a repeated word, post delay 3, random back-pressure
    rdy_rand = 1;
    arm_go(3);
    send(5, 0); send(5, 0); send(7, 0); send(7, 0); send(7, 0);
    send(2, 0); send(2, 1); send(2, 0); send(9, 0); send(9, 0); send(4, 0);
    wait_done("R7");
    chk("R6", int'(trig_hit), 1, "trig_hit");
    chk("R6", int'(trig_idx), m_tidx, "trig_idx");
    chk("R7", m_cnt, 5, "model entry count");

    // long quiet input: repeat entries, then stop
    rdy_rand = 0;
    arm_go(100);
    for (int i = 0; i < 140; i++) send(8'hA5, 0);
    chk("R5", m_cnt, 3, "model entries for quiet run");
    idle(3);
    do_stop();
    wait_done("R9");
    s_valid = 1'b1; s_data = 8'h3C;
    idle(4);
    @(negedge clk);
    chk("R9", int'(s_ready), 0, "s_ready after stop");
    chk("R9", int'(count), 3, "count after stop");
    @(posedge clk); #1;
    s_valid = 1'b0;

    // memory full without a trigger
    rdy_rand = 1;
    arm_go(5);
    for (int i = 0; i < 40; i++) send(i + 1, 0);
    wait_done("R8");
    chk("R8", int'(count), ENT, "count at capacity");
    chk("R6", int'(trig_hit), 0, "no trigger seen");

    // re-arm during a run, first sample kept though unchanged, zero post delay
    rdy_rand = 0;
    arm_go(0);
    send(1, 0); send(2, 0); send(3, 0);
    idle(3);
    arm_go(0);
    send(3, 0); send(3, 1); send(8, 0);
    wait_done("R6");
    chk("R2", m_cnt, 2, "model entries after re-arm");
    chk("R6", int'(trig_idx), 1, "trig_idx after re-arm");

    // trigger on the very first sample, two more samples
    rdy_rand = 1;
    arm_go(2);
    send(6, 1); send(6, 0); send(6, 0); send(7, 0);
    wait_done("R7");
    chk("R6", int'(trig_idx), 0, "trig_idx on first sample");
    chk("R7", int'(count), 1, "single entry");

    summary();
  end
endmodule